// File: doc/BRIEF.md
# Synchronous burst SRAM cycle controller

This block is the cycle controller of a pipelined synchronous burst memory. On each rising clock edge it samples three chip enables, two address strobes (one for a processor and one for a memory controller), a burst-advance input, the write inputs and a sleep request. It then classifies the cycle as a deselect, a sleep cycle, a new read or write burst at the external address, a continued burst, or a suspended burst. From that decision it drives a two-bit burst counter, the byte-lane write strobes of a small internal array, and the drive enable of the tri-state read data bus.

The burst counter supports two address orders, selected by `lin_order`. Read data passes through an output register, so it appears one clock after the read address is registered. The drive enable combines that register with the output-enable input without any clocking, so the bus reacts at once when the output enable changes.

The block has two state machines. The cycle machine has the states CY_IDLE (no burst), CY_RD (read burst) and CY_WR (write burst). Its transitions are:
- load-read: a strobe is accepted while the chip is selected and the cycle is a read.
- load-write: the controller strobe is accepted while the chip is selected and the write condition is true.
- deselect: a strobe is accepted but the chip is not selected; the machine goes to CY_IDLE.
- continue or suspend: no strobe, and a burst is active; the machine goes to CY_RD or CY_WR according to the write condition.
- drop: sleep is requested or the power machine is not running; the machine goes to CY_IDLE.

The power machine has the states ST_RUN, ST_ENT (two-cycle entry), ST_SLP (asleep) and ST_EXIT (two-cycle recovery). Its transitions are:
- ST_RUN to ST_ENT when a sleep request is sampled.
- ST_ENT to ST_SLP after its second cycle.
- ST_SLP to ST_EXIT when the request is seen low.
- ST_EXIT to ST_RUN after its second cycle.

Top module: `sburst_ctrl`

## Requirements
- R1: A strobe that is accepted while the chip is not selected (`en_a_n`=1, `en_b`=0 or `en_c_n`=1) ends any burst. It loads no address, and the bus is not driven one edge later.
- R2: A processor strobe (`cpu_strb_n`=0) sampled with `en_a_n`=1 is ignored. The edge behaves as if that strobe were high, so the controller strobe or the advance input decides the cycle.
- R3: An accepted processor strobe with the chip selected starts a read burst at `addr_in`, whatever `wr_all_n`, `lane_wr_n` and `lane_sel_n` are. `burst_addr` shows `addr_in` after that edge.
- R4: An accepted controller strobe (`ctl_strb_n`=0 with no accepted processor strobe) with the chip selected loads `addr_in`. It starts a write burst if the write condition is true and a read burst otherwise.
- R5: The write condition is true when `wr_all_n`=0, in which case all byte lanes are written. It is also true when `lane_wr_n`=0 and at least one `lane_sel_n` bit is 0; only lanes whose bit is 0 are written, and bit i controls `wdata[8i+7:8i]`. With `wr_all_n`=1 and (`lane_wr_n`=1 or all `lane_sel_n` bits 1), nothing is written. A write takes place at the edge that samples it, at the address shown after that edge.
- R6: With both strobes inactive and a burst active, `burst_adv_n`=0 moves to the next burst address and `burst_adv_n`=1 holds the address. Each such cycle is a write or a read according to the write condition. With no burst active, the advance input has no effect.
- R7: With `lin_order`=1, the low two address bits step start, start+1, start+2, start+3 modulo 4 and then wrap. The upper bits do not change.
- R8: With `lin_order`=0, the low two address bits of step i are start XOR i, for i = 0 to 3, and then the order repeats.
- R9: Data for a read cycle registered at edge k appears on `rdata` after edge k+1.
- R10: `rdata_drive` is 1 only while the output register holds read data, `out_en_n`=0, the current cycle is not a write, and `power_down`=0. It follows `out_en_n` without waiting for a clock edge.
- R11: `power_down` rises after the first edge that samples `sleep_req`=1. After the first edge in ST_SLP that samples `sleep_req`=0, it stays high for one more edge and falls after the second edge.
- R12: From the first edge that samples `sleep_req`=1 until `power_down` has fallen, every strobe is ignored and `burst_addr` holds. Sleep entry also ends the active burst.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| en_a_n | input | 1 | Chip enable A, active low |
| en_b | input | 1 | Chip enable B, active high |
| en_c_n | input | 1 | Chip enable C, active low |
| cpu_strb_n | input | 1 | Processor address strobe, active low |
| ctl_strb_n | input | 1 | Controller address strobe, active low |
| burst_adv_n | input | 1 | Burst advance, active low |
| wr_all_n | input | 1 | Global write, active low |
| lane_wr_n | input | 1 | Byte-write enable, active low |
| lane_sel_n | input | NB | Per-lane write selects, active low |
| sleep_req | input | 1 | Sleep request |
| out_en_n | input | 1 | Output enable, active low, not clocked |
| lin_order | input | 1 | 1 = linear burst order, 0 = interleaved |
| addr_in | input | AW | External address |
| wdata | input | NB*8 | Write data |
| rdata | output | NB*8 | Registered read data |
| rdata_drive | output | 1 | Drive enable for the read data bus |
| burst_addr | output | AW | Current burst address |
| power_down | output | 1 | Power machine not in ST_RUN |

## Verification
Three results have different delays. `burst_addr` and `power_down` change at the edge that samples the command or the sleep request. `rdata` and the output-register part of `rdata_drive` change one edge later. The `out_en_n` part of `rdata_drive` changes with no edge at all. The bench changes inputs and samples outputs 2 ns after a rising edge, so every expected value in the vector table belongs to the edge just passed: a read row shows its data in the next row. The output-enable check toggles `out_en_n` between edges and samples after a 1 ns settle. The recovery check counts the exact number of edges before `power_down` falls.

// File: rtl/sburst_pkg.sv
package sburst_pkg;
    typedef enum logic [1:0] {
        CY_IDLE = 2'd0,
        CY_RD   = 2'd1,
        CY_WR   = 2'd2
    } cyc_e;

    typedef enum logic [1:0] {
        ST_RUN  = 2'd0,
        ST_ENT  = 2'd1,
        ST_SLP  = 2'd2,
        ST_EXIT = 2'd3
    } pwr_e;
endpackage

// File: rtl/sburst_pwr.sv
module sburst_pwr
    import sburst_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic sleep_req,
    output logic go,
    output logic power_down
);
    pwr_e st_q, st_d;
    logic cnt_q, cnt_d;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q  <= ST_RUN;
            cnt_q <= 1'b0;
        end else begin
            st_q  <= st_d;
            cnt_q <= cnt_d;
        end
    end

    always_comb begin
        st_d  = st_q;
        cnt_d = 1'b0;
        unique case (st_q)
            ST_RUN:  if (sleep_req) st_d = ST_ENT;
            ST_ENT:  if (cnt_q) st_d = ST_SLP; else cnt_d = 1'b1;
            ST_SLP:  if (!sleep_req) st_d = ST_EXIT;
            ST_EXIT: if (cnt_q) st_d = ST_RUN; else cnt_d = 1'b1;
        endcase
    end

    assign go         = (st_q == ST_RUN) && !sleep_req;
    assign power_down = (st_q != ST_RUN);

    AST_SLEEP_ENTER: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q == ST_RUN && sleep_req) |=> (st_q == ST_ENT)); // R11
    AST_SLEEP_LEAVE: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q == ST_SLP && !sleep_req) |=> (st_q == ST_EXIT)); // R11
endmodule

// File: rtl/sburst_cyc.sv
module sburst_cyc
    import sburst_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic go,
    input  logic sel,
    input  logic en_a_n,
    input  logic cpu_strb_n,
    input  logic ctl_strb_n,
    input  logic burst_adv_n,
    input  logic wr_cond,
    output cyc_e cyc_q,
    output cyc_e cyc_nxt,
    output logic load,
    output logic adv
);
    logic cpu_take;

    assign cpu_take = !cpu_strb_n && !en_a_n;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cyc_q <= CY_IDLE;
        else        cyc_q <= cyc_nxt;
    end

    always_comb begin
        cyc_nxt = cyc_q;
        load    = 1'b0;
        adv     = 1'b0;
        if (!go) begin
            cyc_nxt = CY_IDLE;
        end else if (cpu_take) begin
            if (sel) begin
                cyc_nxt = CY_RD;
                load    = 1'b1;
            end else begin
                cyc_nxt = CY_IDLE;
            end
        end else if (!ctl_strb_n) begin
            if (sel) begin
                cyc_nxt = wr_cond ? CY_WR : CY_RD;
                load    = 1'b1;
            end else begin
                cyc_nxt = CY_IDLE;
            end
        end else begin
            unique case (cyc_q)
                CY_IDLE: cyc_nxt = CY_IDLE;
                CY_RD, CY_WR: begin
                    adv     = !burst_adv_n;
                    cyc_nxt = wr_cond ? CY_WR : CY_RD;
                end
            endcase
        end
    end

    AST_CPU_READ: assert property (@(posedge clk) disable iff (!rst_n)
        (go && cpu_take && sel) |=> (cyc_q == CY_RD)); // R3
endmodule

// File: rtl/sburst_cnt.sv
module sburst_cnt #(
    parameter int AW = 6,
    parameter int BB = 2
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          lin_order,
    input  logic          load,
    input  logic          adv,
    input  logic [AW-1:0] ld_addr,
    output logic [AW-1:0] nxt_addr,
    output logic [AW-1:0] cur_addr
);
    localparam logic [BB-1:0] ONE = BB'(1);

    logic [AW-1:0] base_q, base_d;
    logic [BB-1:0] idx_q, idx_d;

    function automatic logic [AW-1:0] form(input logic [AW-1:0] b,
                                           input logic [BB-1:0] i,
                                           input logic lin);
        logic [BB-1:0] lo;
        lo = lin ? (b[BB-1:0] + i) : (b[BB-1:0] ^ i);
        return {b[AW-1:BB], lo};
    endfunction

    assign base_d   = load ? ld_addr : base_q;
    assign idx_d    = load ? '0 : (adv ? idx_q + ONE : idx_q);
    assign nxt_addr = form(base_d, idx_d, lin_order);
    assign cur_addr = form(base_q, idx_q, lin_order);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            base_q <= '0;
            idx_q  <= '0;
        end else begin
            base_q <= base_d;
            idx_q  <= idx_d;
        end
    end

    AST_CNT_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
        load |=> (cur_addr == $past(ld_addr))); // R4
    AST_CNT_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (!load && !adv) |=> ($stable(cur_addr) || (lin_order != $past(lin_order)))); // R6
endmodule

// File: rtl/sburst_ram.sv
module sburst_ram #(
    parameter int AW = 6,
    parameter int NB = 4,
    parameter int LW = 8
) (
    input  logic             clk,
    input  logic [NB-1:0]    we_lanes,
    input  logic [AW-1:0]    waddr,
    input  logic [NB*LW-1:0] wdata,
    input  logic             rd_en,
    input  logic [AW-1:0]    raddr,
    output logic [NB*LW-1:0] rdata
);
    localparam int DEPTH = 1 << AW;

    for (genvar g = 0; g < NB; g++) begin : g_lane
        logic [LW-1:0] lane_mem [DEPTH];
        logic [LW-1:0] lane_q;

        always_ff @(posedge clk) begin
            if (we_lanes[g]) lane_mem[waddr] <= wdata[g*LW +: LW];
            if (rd_en)       lane_q          <= lane_mem[raddr];
        end

        assign rdata[g*LW +: LW] = lane_q;
    end
endmodule

// File: rtl/sburst_ctrl.sv
module sburst_ctrl
    import sburst_pkg::*;
#(
    parameter int AW = 6,
    parameter int NB = 4
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            en_a_n,
    input  logic            en_b,
    input  logic            en_c_n,
    input  logic            cpu_strb_n,
    input  logic            ctl_strb_n,
    input  logic            burst_adv_n,
    input  logic            wr_all_n,
    input  logic            lane_wr_n,
    input  logic [NB-1:0]   lane_sel_n,
    input  logic            sleep_req,
    input  logic            out_en_n,
    input  logic            lin_order,
    input  logic [AW-1:0]   addr_in,
    input  logic [NB*8-1:0] wdata,
    output logic [NB*8-1:0] rdata,
    output logic            rdata_drive,
    output logic [AW-1:0]   burst_addr,
    output logic            power_down
);
    localparam int LW = 8;
    localparam int BB = 2;

    logic          go, sel, wr_cond, load, adv, out_rd_q;
    logic [NB-1:0] lanes, we_lanes;
    logic [AW-1:0] nxt_addr, cur_addr;
    cyc_e          cyc_q, cyc_nxt;

    assign sel     = !en_a_n && en_b && !en_c_n;
    assign lanes   = !wr_all_n ? '1 : (!lane_wr_n ? ~lane_sel_n : '0);
    assign wr_cond = |lanes;

    sburst_pwr u_pwr (
        .clk(clk), .rst_n(rst_n), .sleep_req(sleep_req),
        .go(go), .power_down(power_down)
    );

    sburst_cyc u_cyc (
        .clk(clk), .rst_n(rst_n), .go(go), .sel(sel), .en_a_n(en_a_n),
        .cpu_strb_n(cpu_strb_n), .ctl_strb_n(ctl_strb_n),
        .burst_adv_n(burst_adv_n), .wr_cond(wr_cond),
        .cyc_q(cyc_q), .cyc_nxt(cyc_nxt), .load(load), .adv(adv)
    );

    sburst_cnt #(.AW(AW), .BB(BB)) u_cnt (
        .clk(clk), .rst_n(rst_n), .lin_order(lin_order), .load(load),
        .adv(adv), .ld_addr(addr_in), .nxt_addr(nxt_addr), .cur_addr(cur_addr)
    );

    assign we_lanes = (cyc_nxt == CY_WR) ? lanes : '0;

    sburst_ram #(.AW(AW), .NB(NB), .LW(LW)) u_ram (
        .clk(clk), .we_lanes(we_lanes), .waddr(nxt_addr), .wdata(wdata),
        .rd_en(cyc_q == CY_RD), .raddr(cur_addr), .rdata(rdata)
    );

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) out_rd_q <= 1'b0;
        else        out_rd_q <= (cyc_q == CY_RD);
    end

    assign rdata_drive = out_rd_q && !out_en_n && (cyc_q != CY_WR) && !power_down;
    assign burst_addr  = cur_addr;

    AST_WR_LANES: assert property (@(posedge clk) disable iff (!rst_n)
        (cyc_nxt == CY_WR) |-> (we_lanes != '0)); // R5
    AST_PD_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        power_down |=> (cyc_q == CY_IDLE)); // R12
endmodule

// File: tb/sburst_ctrl_bench.sv
module sburst_ctrl_bench;
    localparam int AW = 6;
    localparam int NB = 4;
    localparam logic L = 1'b0;
    localparam logic H = 1'b1;

    typedef struct packed {
        logic a_n, b, c_n, p_n, s_n, v_n, g_n;
        logic [5:0] ad;
        logic [7:0] sd;
        logic eo;
        logic [7:0] ed;
        logic [5:0] ea;
    } vec_t;

    localparam int NV = 22;
    localparam vec_t VT [NV] = '{
        '{L,H,L,H,L,H,L,6'd4,8'h11,L,8'h00,6'd4},  // R4 write start
        '{L,H,L,H,H,L,L,6'd4,8'h22,L,8'h00,6'd5},  // R6 R7 continue write
        '{L,H,L,H,H,L,L,6'd4,8'h33,L,8'h00,6'd6},
        '{L,H,L,H,H,L,L,6'd4,8'h44,L,8'h00,6'd7},
        '{L,H,L,H,H,L,L,6'd4,8'h55,L,8'h00,6'd4},  // R7 wrap
        '{L,H,L,L,H,H,L,6'd6,8'h00,L,8'h00,6'd6},  // R3 read despite write inputs
        '{L,H,L,H,H,L,H,6'd0,8'h00,H,8'h33,6'd7},  // R9 data one edge later
        '{L,H,L,H,H,L,H,6'd0,8'h00,H,8'h44,6'd4},
        '{L,H,L,H,H,H,H,6'd0,8'h00,H,8'h55,6'd4},  // R6 suspend
        '{L,H,L,H,H,H,H,6'd0,8'h00,H,8'h55,6'd4},
        '{H,H,L,H,L,H,H,6'd0,8'h00,H,8'h55,6'd4},  // R1 deselect via ctl strobe
        '{L,H,L,H,H,L,H,6'd0,8'h00,L,8'h00,6'd4},  // R1 R6 idle, advance no effect
        '{H,H,L,L,H,H,H,6'd9,8'h00,L,8'h00,6'd4},  // R2 ignored strobe
        '{L,L,L,L,H,H,H,6'd8,8'h00,L,8'h00,6'd4},  // R1 en_b low
        '{L,H,L,H,L,H,H,6'd5,8'h00,L,8'h00,6'd5},  // R4 read start
        '{H,H,L,L,H,L,H,6'd9,8'h00,H,8'h22,6'd6},  // R2 ignored, burst continues
        '{L,H,H,L,H,H,H,6'd9,8'h00,H,8'h33,6'd6},  // R1 en_c_n high
        '{L,H,L,H,H,H,H,6'd0,8'h00,L,8'h00,6'd6},  // R1 no drive
        '{L,H,L,H,L,H,H,6'd7,8'h00,L,8'h00,6'd7},
        '{L,H,L,H,L,H,L,6'd7,8'h66,L,8'h00,6'd7},  // R10 write masks drive
        '{L,H,L,H,L,H,H,6'd7,8'h00,L,8'h00,6'd7},
        '{L,H,L,H,H,H,H,6'd0,8'h00,H,8'h66,6'd7}
    };

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic en_a_n, en_b, en_c_n, cpu_strb_n, ctl_strb_n, burst_adv_n;
    logic wr_all_n, lane_wr_n, sleep_req, out_en_n, lin_order;
    logic [NB-1:0]   lane_sel_n;
    logic [AW-1:0]   addr_in;
    logic [NB*8-1:0] wdata, rdata;
    logic            rdata_drive, power_down;
    logic [AW-1:0]   burst_addr;

    int total = 0;
    int bad = 0;
    bit done = 0;

    always #4 clk = ~clk;

    sburst_ctrl #(.AW(AW), .NB(NB)) u_sburst_ctrl (
        .clk(clk), .rst_n(rst_n), .en_a_n(en_a_n), .en_b(en_b), .en_c_n(en_c_n),
        .cpu_strb_n(cpu_strb_n), .ctl_strb_n(ctl_strb_n), .burst_adv_n(burst_adv_n),
        .wr_all_n(wr_all_n), .lane_wr_n(lane_wr_n), .lane_sel_n(lane_sel_n),
        .sleep_req(sleep_req), .out_en_n(out_en_n), .lin_order(lin_order),
        .addr_in(addr_in), .wdata(wdata), .rdata(rdata), .rdata_drive(rdata_drive),
        .burst_addr(burst_addr), .power_down(power_down)
    );

    task automatic chk(input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s %s: actual=%h expected=%h", req, what, act, exp);
        end
    endtask

    task automatic tick();
        @(posedge clk);
        #2;
    endtask

    task automatic idle_in();
        en_a_n = 0; en_b = 1; en_c_n = 0;
        cpu_strb_n = 1; ctl_strb_n = 1; burst_adv_n = 1;
        wr_all_n = 1; lane_wr_n = 1; lane_sel_n = '1;
        addr_in = '0; wdata = '0;
    endtask

    task automatic ctl_cmd(input logic [AW-1:0] a, input logic g_n, input logic bw_n,
                           input logic [NB-1:0] ls_n, input logic [31:0] d);
        idle_in();
        ctl_strb_n = 0; addr_in = a; wr_all_n = g_n;
        lane_wr_n = bw_n; lane_sel_n = ls_n; wdata = d;
    endtask

    initial begin
        #(8 * 20000);
        if (!done) begin
            total++; bad++;
            $display("FAIL watchdog: actual=running expected=finished");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        idle_in();
        sleep_req = 0; out_en_n = 0; lin_order = 1;
        repeat (3) @(posedge clk);
        #2;
        chk("R10", "reset drive", {31'd0, rdata_drive}, 32'd0);
        chk("R11", "reset power_down", {31'd0, power_down}, 32'd0);
        chk("R6", "reset burst_addr", {26'd0, burst_addr}, 32'd0);
        rst_n = 1;
        tick();

        // vector table: R1 R2 R3 R4 R6 R7 R9 R10
        for (int i = 0; i < NV; i++) begin
            idle_in();
            en_a_n = VT[i].a_n; en_b = VT[i].b; en_c_n = VT[i].c_n;
            cpu_strb_n = VT[i].p_n; ctl_strb_n = VT[i].s_n;
            burst_adv_n = VT[i].v_n; wr_all_n = VT[i].g_n;
            addr_in = VT[i].ad; wdata = {4{VT[i].sd}};
            tick();
            chk($sformatf("R1 R2 R3 R4 R6 R7 R9 row %0d", i), "burst_addr",
                {26'd0, burst_addr}, {26'd0, VT[i].ea});
            chk($sformatf("R10 row %0d", i), "drive",
                {31'd0, rdata_drive}, {31'd0, VT[i].eo});
            if (VT[i].eo)
                chk($sformatf("R9 row %0d", i), "rdata", rdata, {4{VT[i].ed}});
        end

        // R10 output enable acts without a clock edge
        idle_in();
        out_en_n = 1; #1;
        chk("R10", "async disable", {31'd0, rdata_drive}, 32'd0);
        out_en_n = 0; #1;
        chk("R10", "async enable", {31'd0, rdata_drive}, 32'd1);
        tick();

        // R5 byte lanes and write condition
        ctl_cmd(6'd10, 0, 1, 4'hF, 32'hAAAAAAAA); tick();
        ctl_cmd(6'd10, 1, 0, 4'b1010, 32'h11223344); tick();
        chk("R5", "partial write addr", {26'd0, burst_addr}, 32'd10);
        ctl_cmd(6'd10, 1, 0, 4'hF, 32'hFFFFFFFF); tick();
        idle_in(); tick();
        chk("R5", "no-lane is read drive", {31'd0, rdata_drive}, 32'd1);
        chk("R5", "lane merge", rdata, 32'hAA22AA44);
        ctl_cmd(6'd10, 1, 1, 4'h0, 32'hFFFFFFFF); tick();
        idle_in(); tick();
        chk("R5", "lane write ignored without enable", rdata, 32'hAA22AA44);

        // R8 interleaved order from low bits 01
        lin_order = 0;
        ctl_cmd(6'h11, 0, 1, 4'hF, 32'h0); tick();
        chk("R8", "load", {26'd0, burst_addr}, 32'h11);
        idle_in(); burst_adv_n = 0; tick();
        chk("R8", "step1", {26'd0, burst_addr}, 32'h10);
        tick();
        chk("R8", "step2", {26'd0, burst_addr}, 32'h13);
        tick();
        chk("R8", "step3", {26'd0, burst_addr}, 32'h12);
        tick();
        chk("R8", "wrap", {26'd0, burst_addr}, 32'h11);
        lin_order = 1;
        idle_in(); tick();

        // R11 R12 sleep entry and recovery
        ctl_cmd(6'd20, 1, 1, 4'hF, 32'h0); tick();
        ctl_cmd(6'd21, 1, 1, 4'hF, 32'h0); sleep_req = 1; tick();
        chk("R11", "enter", {31'd0, power_down}, 32'd1);
        chk("R10", "sleep tri-state", {31'd0, rdata_drive}, 32'd0);
        chk("R12", "request ignored on entry", {26'd0, burst_addr}, 32'd20);
        repeat (3) tick();
        chk("R12", "request ignored asleep", {26'd0, burst_addr}, 32'd20);
        sleep_req = 0; ctl_cmd(6'd22, 1, 1, 4'hF, 32'h0); tick();
        chk("R11", "recovery edge 1", {31'd0, power_down}, 32'd1);
        tick();
        chk("R11", "recovery edge 2", {31'd0, power_down}, 32'd1);
        tick();
        chk("R11", "recovered", {31'd0, power_down}, 32'd0);
        chk("R12", "request ignored on recovery", {26'd0, burst_addr}, 32'd20);
        ctl_cmd(6'd23, 1, 1, 4'hF, 32'h0); tick();
        chk("R12", "accepted after recovery", {26'd0, burst_addr}, 32'd23);
        idle_in(); tick();
        chk("R9", "read after recovery", {31'd0, rdata_drive}, 32'd1);

        done = 1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule